// File: doc/BRIEF.md
# Latency-Targeted Random Program Generator

This block turns a 64-bit per-block seed into a random straight-line integer program for the inner loop of a hash. Because the seed comes from the block height, the program does not change for the whole block, so it can be produced well before it is needed. Instructions leave the block one at a time over a valid/ready stream. A downstream compiler or loader consumes them.

The program has no fixed length. For each of its eight registers the generator keeps the cycle in which the register's value becomes ready, assuming as many parallel ALUs as needed. It stops adding instructions once the modelled critical path has reached a latency budget and the program has reached a minimum length. A hard maximum length also stops it. A 64-bit xorshift generator picks the opcode and both register operands of every instruction.

Top module: `rprog_gen`

## Requirements
- R1: While reset is held and on the first cycle after it, `ins_valid` and `done` are 0 and `count` and `latency` are 0.
- R2: A `start` pulse while the block is not generating loads the xorshift state from `seed`. A seed of zero is replaced by 64'h9E3779B97F4A7C15. On the next cycle `ins_valid` is 1, `done` is 0, `count` is 0 and `latency` is 0.
- R3: Each instruction is built from the current state `s`. The opcode is `s[2:0]` reduced modulo 6, the destination is `s[5:3]` and the source is `s[8:6]`. The 10-bit word is {1'b0, opcode[2:0], dst[2:0], src[2:0]}. The opcodes are 0 multiply, 1 add, 2 subtract, 3 rotate right, 4 rotate left and 5 xor.
- R4: For add (1) and xor (5), if the drawn source equals the destination, the source is replaced by that index with bit 0 inverted.
- R5: The state advances by one xorshift64 step (x^=x<<13; x^=x>>7; x^=x<<17) only when an instruction is accepted (`ins_valid && ins_ready`). While the instruction is stalled, `ins_data` and `count` hold their values.
- R6: Each accepted instruction completes at max(ready[dst], ready[src]) plus 3 for a multiply or plus 1 for any other opcode. That value becomes ready[dst], and `latency` is the largest completion seen since start. All ready times start at 0.
- R7: The instruction that makes `count` reach 69 ends generation. So does an instruction after which `latency` >= `target` and `count` >= 60. From the next cycle `done` is 1 and `ins_valid` is 0.
- R8: A `start` pulse while instructions are still being emitted has no effect.
- R9: A `start` pulse after `done` begins a new program from the new seed, with all ready times cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a program from `seed` |
| seed | input | 64 | Per-block seed |
| target | input | 8 | Latency budget in cycles |
| ins_valid | output | 1 | Instruction word available |
| ins_ready | input | 1 | Consumer accepts the word |
| ins_data | output | 10 | Instruction word |
| done | output | 1 | Program complete |
| count | output | 7 | Instructions accepted so far |
| latency | output | 8 | Modelled critical-path latency so far |

## Verification
The first instruction word appears in the cycle after the edge that samples `start`. Each word is emitted combinationally from the state, so it is checked in the same cycle it is offered. `count`, `latency` and the next word change only at the edge that accepts a word. `done` rises at the edge that accepts the final word. The bench drives inputs and samples outputs on falling edges, and it moves its reference model forward only after a rising edge in which it held `ins_ready` high. Every comparison is made one full edge after the stimulus that caused it.

// File: rtl/rprog_gen.sv
module rprog_gen #(
  parameter int NREG    = 8,
  parameter int LAT_W   = 8,
  parameter int MIN_LEN = 60,
  parameter int MAX_LEN = 69,
  parameter int MUL_LAT = 3,
  localparam int RW     = $clog2(NREG),
  localparam int CW     = $clog2(MAX_LEN + 1),
  localparam int INS_W  = 4 + 2 * RW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [63:0]      seed,
  input  logic [LAT_W-1:0] target,
  output logic             ins_valid,
  input  logic             ins_ready,
  output logic [INS_W-1:0] ins_data,
  output logic             done,
  output logic [CW-1:0]    count,
  output logic [LAT_W-1:0] latency
);
  localparam logic [63:0] SEED_ALT = 64'h9E3779B97F4A7C15;
  localparam logic [2:0]  OP_MUL = 3'd0, OP_ADD = 3'd1, OP_XOR = 3'd5;

  logic [63:0]      st;
  logic             busy;
  logic [LAT_W-1:0] rdy [NREG];

  function automatic logic [63:0] xs_step(input logic [63:0] x);
    logic [63:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 7);
    y = y ^ (y << 17);
    return y;
  endfunction

  wire  [2:0]    op_raw = st[2:0];
  wire  [2:0]    op     = (op_raw >= 3'd6) ? op_raw - 3'd6 : op_raw;
  wire  [RW-1:0] dst    = st[RW+2:3];
  wire  [RW-1:0] src_r  = st[2*RW+2:RW+3];
  wire           clash  = (op == OP_ADD || op == OP_XOR) && (src_r == dst);
  wire  [RW-1:0] src    = clash ? (src_r ^ {{(RW-1){1'b0}}, 1'b1}) : src_r;

  wire [LAT_W-1:0] ra   = rdy[dst];
  wire [LAT_W-1:0] rb   = rdy[src];
  wire [LAT_W-1:0] comp = ((ra > rb) ? ra : rb) +
                          ((op == OP_MUL) ? LAT_W'(MUL_LAT) : LAT_W'(1));
  wire [LAT_W-1:0] lat_n = (comp > latency) ? comp : latency;
  wire [CW-1:0]    cnt_n = count + CW'(1);
  wire             fire  = busy && ins_ready;
  wire             stop  = (cnt_n == CW'(MAX_LEN)) ||
                           ((lat_n >= target) && (cnt_n >= CW'(MIN_LEN)));

  assign ins_valid = busy;
  assign ins_data  = {1'b0, op, dst, src};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      count   <= '0;
      latency <= '0;
      for (int i = 0; i < NREG; i++) rdy[i] <= '0;
    end else if (start && !busy) begin
      st      <= (seed == 64'd0) ? SEED_ALT : seed;
      busy    <= 1'b1;
      done    <= 1'b0;
      count   <= '0;
      latency <= '0;
      for (int i = 0; i < NREG; i++) rdy[i] <= '0;
    end else if (fire) begin
      st       <= xs_step(st);
      rdy[dst] <= comp;
      latency  <= lat_n;
      count    <= cnt_n;
      if (stop) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rprog_gen_chk.sv
module rprog_gen_chk #(
  parameter int NREG    = 8,
  parameter int LAT_W   = 8,
  parameter int MIN_LEN = 60,
  parameter int MAX_LEN = 69,
  localparam int RW     = $clog2(NREG),
  localparam int CW     = $clog2(MAX_LEN + 1),
  localparam int INS_W  = 4 + 2 * RW
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ins_valid,
  input logic             ins_ready,
  input logic [INS_W-1:0] ins_data,
  input logic             done,
  input logic [CW-1:0]    count,
  input logic [LAT_W-1:0] latency
);
  wire [2:0]    c_op  = ins_data[INS_W-2:2*RW];
  wire [RW-1:0] c_dst = ins_data[2*RW-1:RW];
  wire [RW-1:0] c_src = ins_data[RW-1:0];

  a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ins_valid);
  a_r7_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(MAX_LEN));
  a_r7_done_min: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> count >= CW'(MIN_LEN));
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && !ins_ready |=> ins_valid && $stable(ins_data) && $stable(count));
  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && ins_ready |=> count == $past(count) + CW'(1));
  a_r3_format: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |-> !ins_data[INS_W-1] && c_op < 3'd6);
  a_r4_distinct: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && (c_op == 3'd1 || c_op == 3'd5) |-> c_dst != c_src);
  a_r6_lat_mono: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |=> latency >= $past(latency));
endmodule

bind rprog_gen rprog_gen_chk #(.NREG(NREG), .LAT_W(LAT_W), .MIN_LEN(MIN_LEN),
  .MAX_LEN(MAX_LEN)) u_chk (.*);

// File: tb/rprog_gen_tb.sv
`timescale 1ns/1ps
module rprog_gen_tb;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, ins_ready = 1'b0;
  logic [63:0] seed = '0;
  logic [7:0]  target = '0;
  logic        ins_valid, done;
  logic [9:0]  ins_data;
  logic [6:0]  count;
  logic [7:0]  latency;
  int n_cmp = 0, n_bad = 0, cyc = 0;

  always #5 clk = ~clk;

  rprog_gen u_dut (.clk(clk), .rst_n(rst_n), .start(start), .seed(seed),
    .target(target), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_data(ins_data), .done(done), .count(count), .latency(latency));

  function automatic logic [63:0] xs(input logic [63:0] x);
    logic [63:0] y;
    y = x ^ (x << 13); y = y ^ (y >> 7); y = y ^ (y << 17);
    return y;
  endfunction

  logic [63:0] mst;
  logic [7:0]  mr [8];
  logic [7:0]  mlat;
  int          mcnt;
  logic        mstop;
  logic [2:0]  eop, edst, esrc;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic decode();
    eop  = (mst[2:0] >= 3'd6) ? mst[2:0] - 3'd6 : mst[2:0];
    edst = mst[5:3];
    esrc = mst[8:6];
    if ((eop == 3'd1 || eop == 3'd5) && esrc == edst) esrc = esrc ^ 3'd1;
  endtask

  task automatic advance(input logic [7:0] t);
    logic [7:0] a, b, c;
    decode();
    a = mr[edst]; b = mr[esrc];
    c = ((a > b) ? a : b) + ((eop == 3'd0) ? 8'd3 : 8'd1);
    mr[edst] = c;
    if (c > mlat) mlat = c;
    mcnt++;
    mst = xs(mst);
    mstop = (mcnt == 69) || (mlat >= t && mcnt >= 60);
  endtask

  task automatic run_prog(input logic [63:0] s, input logic [7:0] t,
                          input int pct, input bit inj);
    logic [9:0] held;
    bit r;
    @(negedge clk);
    start = 1'b1; seed = s; target = t;
    mst = (s == 64'd0) ? 64'h9E3779B97F4A7C15 : s;
    for (int i = 0; i < 8; i++) mr[i] = 8'd0;
    mlat = 8'd0; mcnt = 0; mstop = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk("R2 valid after start", ins_valid, 1);
    chk("R2/R9 count cleared", count, 0);
    chk("R2/R9 latency cleared", latency, 0);
    while (!mstop) begin
      decode();
      chk("R3/R4 instruction word", ins_data, {1'b0, eop, edst, esrc});
      if (inj && mcnt == 5) begin
        held = ins_data;
        ins_ready = 1'b0; start = 1'b1; seed = ~s;
        @(negedge clk);
        start = 1'b0;
        chk("R8 start ignored word", ins_data, held);
        chk("R8 start ignored count", count, 5);
      end
      r = ($urandom_range(99) < pct);
      ins_ready = r;
      @(posedge clk);
      if (r) advance(t);
      @(negedge clk);
      if (!mstop) chk("R5 count", count, mcnt);
    end
    ins_ready = 1'b0;
    chk("R7 done", done, 1);
    chk("R7 valid low", ins_valid, 0);
    chk("R7 length", count, mcnt);
    chk("R6 latency", latency, mlat);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 valid", ins_valid, 0);
    chk("R1 done", done, 0);
    chk("R1 count", count, 0);
    chk("R1 latency", latency, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after release", ins_valid, 0);
    run_prog(64'd0, 8'd45, 100, 1'b0);
    run_prog(64'h0123_4567_89AB_CDEF, 8'd0, 100, 1'b0);
    chk("R7 min length with zero target", count, 60);
    run_prog(64'hDEAD_BEEF_CAFE_F00D, 8'd255, 60, 1'b0);
    chk("R7 max length with huge target", count, 69);
    run_prog(64'h5555_AAAA_1234_8765, 8'd45, 50, 1'b1);
    for (int k = 0; k < 8; k++)
      run_prog({$urandom, $urandom}, 8'($urandom_range(30, 70)), 70, k[0]);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule